// File: doc/BRIEF.md
# General Call Command Decoder

This block follows the bytes a bus slave receives and watches for a broadcast ("general call") transaction. It looks only at the first byte after a start condition. If that byte is one of the two general-call address values, the block treats the byte that follows as a command. It turns that command into a sticky interrupt status, a two-bit identifier, and, for one command value, a one-cycle request to reset the serial interface. It also gives an acknowledge hint while it is waiting for the command byte, so that the bit-level engine knows the next byte belongs to the decoder.

Received bytes come in on a valid/ready stream. The decoder never applies back-pressure: `rx_ready` is held high, and a byte is consumed on every clock edge at which `rx_valid` is high. The upstream side may hold `rx_valid` low for any number of cycles between bytes, and the decoder state does not move while it is low. Start, stop and status-clear are plain single-cycle strobes. When events coincide, stop has priority over start, and start has priority over a byte.

Top module: `gc_cmd_decoder`

## Requirements
- R1: After reset, `gc_status`, `if_reset_pulse` and `ack_hint` are 0 and `gc_id` is 0.
- R2: A byte flagged `rx_first` that arrives after a start and whose value is 0x00 or 0x01 is taken as a general-call address. `ack_hint` is 1 from the next cycle until the command byte is consumed, a stop arrives, or a start arrives.
- R3: After address 0x00, command 0x06 sets `gc_status` to 1 and `gc_id` to 1, and raises `if_reset_pulse`. All three appear in the cycle after the command byte is consumed.
- R4: After address 0x00, command 0x04 sets `gc_status` to 1 and `gc_id` to 2, with no reset pulse.
- R5: Any other command byte, and any command byte after address 0x01, sets `gc_status` to 1 and `gc_id` to 3, with no reset pulse.
- R6: A first byte after a start that is not 0x00 or 0x01 disarms the decoder. Later bytes in that transfer change none of the outputs.
- R7: Bytes consumed while no start is pending are ignored. A stop while waiting for the command byte abandons the sequence.
- R8: `status_clr` returns `gc_status` and `gc_id` to 0 in the next cycle. If a command is decoded in the same cycle, the new result is kept. `gc_id` is nonzero exactly when `gc_status` is 1.
- R9: `if_reset_pulse` lasts exactly one clock and leaves `gc_status` and `gc_id` unchanged.
- R10: `rx_ready` is always 1. A byte is consumed on each edge where `rx_valid` is 1.
- R11: A byte that arrives after a start without the `rx_first` flag disarms the decoder and is not examined as an address.
- R12: `gc_status` and `gc_id` change only in the cycle after a consumed byte or a `status_clr`.
- R13: A repeated start while waiting for the command byte re-arms the decoder. The next flagged first byte is examined as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Decoder accepts a byte (always 1) |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first one after a start |
| bus_start | input | 1 | Start or repeated start seen on the bus |
| bus_stop | input | 1 | Stop seen on the bus |
| status_clr | input | 1 | Clear the status and identifier |
| gc_status | output | 1 | Sticky general-call status |
| gc_id | output | 2 | 0 none, 1 reset command, 2 command 0x04, 3 other |
| if_reset_pulse | output | 1 | One-cycle interface reset request |
| ack_hint | output | 1 | Next byte is the general-call command |

## Verification
On every cycle, the assertions check the following invariants: the reset pulse is one cycle wide and always comes with status set and identifier 1; it follows a byte consumed while the acknowledge hint was high; status and identifier agree; they hold when no byte and no clear arrives; a clear without a competing command empties them; and start or stop drops the hint. Only the bench scenarios can show which command value maps to which identifier, and that the two address values are told apart. The same holds for the effect of a non-broadcast first byte, an unflagged byte, stray bytes outside a transfer, a stop or repeated start in mid-sequence, and a clear that coincides with a command.

// File: rtl/gc_pkg.sv
package gc_pkg;

  typedef enum logic [1:0] {
    GC_IDLE     = 2'd0,
    GC_ARMED    = 2'd1,
    GC_WAIT_CMD = 2'd2
  } gc_state_e;

  typedef enum logic [1:0] {
    GCID_NONE  = 2'd0,
    GCID_RESET = 2'd1,
    GCID_CMD2  = 2'd2,
    GCID_OTHER = 2'd3
  } gc_id_e;

  typedef struct packed {
    logic   fire;
    logic   reset_req;
    gc_id_e id;
  } gc_event_t;

endpackage

// File: rtl/gc_arm_fsm.sv
module gc_arm_fsm
  import gc_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] GC_ADDR_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              take,
  input  logic              first,
  input  logic [DATA_W-1:0] data,
  output logic              waiting,
  output logic              addr_base,
  output logic              cmd_take
);

  localparam int unsigned HI = DATA_W - 1;

  gc_state_e state_q, state_d;
  logic      base_q;
  logic      load_addr;
  logic      addr_match;
  logic      addr_is_base;

  // the two broadcast addresses differ only in the lowest bit
  assign addr_match   = (data[HI:1] == GC_ADDR_BASE[HI:1]);
  assign addr_is_base = (data[0] == GC_ADDR_BASE[0]);

  always_comb begin
    state_d   = state_q;
    load_addr = 1'b0;
    cmd_take  = 1'b0;
    if (bus_stop) begin
      state_d = GC_IDLE;
    end else if (bus_start) begin
      state_d = GC_ARMED;
    end else if (take) begin
      unique case (state_q)
        GC_ARMED: begin
          if (first && addr_match) begin
            state_d   = GC_WAIT_CMD;
            load_addr = 1'b1;
          end else begin
            state_d = GC_IDLE;
          end
        end
        GC_WAIT_CMD: begin
          cmd_take = 1'b1;
          state_d  = GC_IDLE;
        end
        default: state_d = GC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GC_IDLE;
      base_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_addr) base_q <= addr_is_base;
    end
  end

  assign waiting   = (state_q == GC_WAIT_CMD);
  assign addr_base = base_q;

endmodule

// File: rtl/gc_cmd_map.sv
module gc_cmd_map
  import gc_pkg::*;
#(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] CMD_RESET = 8'h06,
  parameter logic [DATA_W-1:0] CMD_ID2   = 8'h04
) (
  input  logic              cmd_take,
  input  logic              addr_base,
  input  logic [DATA_W-1:0] cmd,
  output gc_event_t         evt
);

  always_comb begin
    evt.fire      = cmd_take;
    evt.reset_req = 1'b0;
    evt.id        = GCID_OTHER;
    if (addr_base) begin
      if (cmd == CMD_RESET) begin
        evt.id        = GCID_RESET;
        evt.reset_req = cmd_take;
      end else if (cmd == CMD_ID2) begin
        evt.id = GCID_CMD2;
      end
    end
  end

endmodule

// File: rtl/gc_status_reg.sv
module gc_status_reg
  import gc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  gc_event_t evt,
  input  logic      clr,
  output logic      status,
  output gc_id_e    id,
  output logic      reset_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status      <= 1'b0;
      id          <= GCID_NONE;
      reset_pulse <= 1'b0;
    end else begin
      reset_pulse <= evt.fire && evt.reset_req;
      if (evt.fire) begin
        status <= 1'b1;
        id     <= evt.id;
      end else if (clr) begin
        status <= 1'b0;
        id     <= GCID_NONE;
      end
    end
  end

endmodule

// File: rtl/gc_cmd_decoder.sv
module gc_cmd_decoder
  import gc_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] GC_ADDR_BASE = '0,
  parameter logic [DATA_W-1:0] CMD_RESET    = 8'h06,
  parameter logic [DATA_W-1:0] CMD_ID2      = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              status_clr,
  output logic              gc_status,
  output logic [1:0]        gc_id,
  output logic              if_reset_pulse,
  output logic              ack_hint
);

  logic      take;
  logic      waiting;
  logic      addr_base;
  logic      cmd_take;
  gc_event_t evt;
  gc_id_e    id_q;

  assign rx_ready = 1'b1;
  assign take     = rx_valid && rx_ready;

  gc_arm_fsm #(
    .DATA_W      (DATA_W),
    .GC_ADDR_BASE(GC_ADDR_BASE)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .take     (take),
    .first    (rx_first),
    .data     (rx_data),
    .waiting  (waiting),
    .addr_base(addr_base),
    .cmd_take (cmd_take)
  );

  gc_cmd_map #(
    .DATA_W   (DATA_W),
    .CMD_RESET(CMD_RESET),
    .CMD_ID2  (CMD_ID2)
  ) i_map (
    .cmd_take (cmd_take),
    .addr_base(addr_base),
    .cmd      (rx_data),
    .evt      (evt)
  );

  gc_status_reg i_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .clr        (status_clr),
    .status     (gc_status),
    .id         (id_q),
    .reset_pulse(if_reset_pulse)
  );

  assign gc_id    = id_q;
  assign ack_hint = waiting;

endmodule

// File: rtl/gc_cmd_decoder_chk.sv
module gc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       bus_start,
  input logic       bus_stop,
  input logic       status_clr,
  input logic       gc_status,
  input logic [1:0] gc_id,
  input logic       if_reset_pulse,
  input logic       ack_hint
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset_pulse |=> !if_reset_pulse); // R9

  AST_PULSE_WITH_ID1: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset_pulse |-> (gc_status && gc_id == 2'd1)); // R3

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset_pulse |-> $past(ack_hint && rx_valid && !bus_stop && !bus_start)); // R3

  AST_STATUS_ID_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    gc_status == (gc_id != 2'd0)); // R8

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !status_clr) |=> ($stable(gc_status) && $stable(gc_id))); // R12

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !(ack_hint && rx_valid)) |=> !gc_status); // R8

  AST_STOP_DROPS_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !ack_hint); // R7

  AST_START_DROPS_HINT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !ack_hint); // R13

endmodule

bind gc_cmd_decoder gc_cmd_decoder_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .bus_start     (bus_start),
  .bus_stop      (bus_stop),
  .status_clr    (status_clr),
  .gc_status     (gc_status),
  .gc_id         (gc_id),
  .if_reset_pulse(if_reset_pulse),
  .ack_hint      (ack_hint)
);

// File: tb/test_gc_cmd_decoder.sv
`timescale 1ns/1ps
module test_gc_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic       rx_first = 1'b0;
  logic       bus_start = 1'b0;
  logic       bus_stop = 1'b0;
  logic       status_clr = 1'b0;
  logic       gc_status;
  logic [1:0] gc_id;
  logic       if_reset_pulse;
  logic       ack_hint;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       st;
    logic [1:0] id;
    logic       pl;
    logic       ack;
    string      req;
  } exp_t;

  exp_t q[$];

  // reference model state: 0 idle, 1 armed, 2 waiting for command
  int         m_state = 0;
  bit         m_base = 1'b0;
  logic       m_status = 1'b0;
  logic [1:0] m_id = 2'd0;

  always #2.5 clk = ~clk;

  gc_cmd_decoder i_gc_cmd_decoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data),
    .rx_first      (rx_first),
    .bus_start     (bus_start),
    .bus_stop      (bus_stop),
    .status_clr    (status_clr),
    .gc_status     (gc_status),
    .gc_id         (gc_id),
    .if_reset_pulse(if_reset_pulse),
    .ack_hint      (ack_hint)
  );

  // monitor: compares each expected item one negedge after it was driven
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (gc_status !== e.st || gc_id !== e.id || if_reset_pulse !== e.pl ||
          ack_hint !== e.ack || rx_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s: st/id/pulse/ack/rdy got %b/%0d/%b/%b/%b expected %b/%0d/%b/%b/1",
                 e.req, gc_status, gc_id, if_reset_pulse, ack_hint, rx_ready,
                 e.st, e.id, e.pl, e.ack);
      end
    end
  end

  // driver: one clock of stimulus, model update, expected item pushed
  task automatic cyc(input logic st, input logic sp, input logic v, input logic f,
                     input logic [7:0] d, input logic c, input string req);
    logic       pl;
    logic       set;
    logic [1:0] nid;
    exp_t       e;
    @(negedge clk);
    #1;
    bus_start = st; bus_stop = sp; rx_valid = v; rx_first = f; rx_data = d; status_clr = c;
    pl = 1'b0; set = 1'b0; nid = 2'd0;
    if (sp) m_state = 0;
    else if (st) m_state = 1;
    else if (v) begin
      if (m_state == 1) begin
        if (f && d[7:1] == 7'd0) begin m_state = 2; m_base = (d == 8'h00); end
        else m_state = 0;
      end else if (m_state == 2) begin
        set = 1'b1; m_state = 0;
        if (m_base && d == 8'h06) begin nid = 2'd1; pl = 1'b1; end
        else if (m_base && d == 8'h04) nid = 2'd2;
        else nid = 2'd3;
      end
    end
    if (set) begin m_status = 1'b1; m_id = nid; end
    else if (c) begin m_status = 1'b0; m_id = 2'd0; end
    e.st = m_status; e.id = m_id; e.pl = pl; e.ack = (m_state == 2); e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    cyc(0, 0, 0, 0, 8'h00, 0, req);
  endtask

  task automatic gc_seq(input logic [7:0] a, input logic [7:0] c, input string req);
    cyc(1, 0, 0, 0, 8'h00, 0, req);
    cyc(0, 0, 1, 1, a, 0, req);
    cyc(0, 0, 1, 0, c, 0, req);
    idle(req);
    cyc(0, 1, 0, 0, 8'h00, 0, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gc_status !== 1'b0 || gc_id !== 2'd0 || if_reset_pulse !== 1'b0 || ack_hint !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset state got %b/%0d/%b/%b expected 0/0/0/0",
               gc_status, gc_id, if_reset_pulse, ack_hint);
    end
    rst_n = 1'b1;
    idle("R1");

    gc_seq(8'h00, 8'h06, "R3 reset command");        // R2 hint, R3 pulse
    idle("R9 pulse gone, status held");
    cyc(0, 0, 0, 0, 8'h00, 1, "R8 clear");
    gc_seq(8'h00, 8'h04, "R4 id 2");
    gc_seq(8'h01, 8'h06, "R5 address 0x01");
    gc_seq(8'h00, 8'h55, "R5 other command");
    cyc(0, 0, 0, 0, 8'h00, 1, "R8 clear");

    // R6 non-broadcast first byte disarms
    cyc(1, 0, 0, 0, 8'h00, 0, "R6");
    cyc(0, 0, 1, 1, 8'hA0, 0, "R6");
    cyc(0, 0, 1, 0, 8'h00, 0, "R6");
    cyc(0, 0, 1, 0, 8'h06, 0, "R6");
    cyc(0, 1, 0, 0, 8'h00, 0, "R6");

    // R7 stray bytes without start, stop while waiting
    cyc(0, 0, 1, 1, 8'h00, 0, "R7 no start");
    cyc(0, 0, 1, 0, 8'h06, 0, "R7 no start");
    cyc(1, 0, 0, 0, 8'h00, 0, "R7");
    cyc(0, 0, 1, 1, 8'h00, 0, "R7");
    cyc(0, 1, 0, 0, 8'h00, 0, "R7 stop abandons");
    cyc(0, 0, 1, 0, 8'h06, 0, "R7 after stop");

    // R11 unflagged byte after start
    cyc(1, 0, 0, 0, 8'h00, 0, "R11");
    cyc(0, 0, 1, 0, 8'h00, 0, "R11 unflagged");
    cyc(0, 0, 1, 0, 8'h04, 0, "R11");

    // R10 gaps in rx_valid do not advance
    cyc(1, 0, 0, 0, 8'h00, 0, "R10");
    cyc(0, 0, 1, 1, 8'h00, 0, "R10");
    idle("R10 gap");
    idle("R10 gap");
    cyc(0, 0, 1, 0, 8'h04, 0, "R10 command after gap");
    cyc(0, 1, 0, 0, 8'h00, 0, "R10");

    // R8 clear coinciding with a command: command wins
    cyc(1, 0, 0, 0, 8'h00, 0, "R8");
    cyc(0, 0, 1, 1, 8'h00, 0, "R8");
    cyc(0, 0, 1, 0, 8'h06, 1, "R8 set beats clear");
    idle("R9 one cycle");
    cyc(0, 1, 0, 0, 8'h00, 1, "R8 clear");

    // R13 repeated start while waiting
    cyc(1, 0, 0, 0, 8'h00, 0, "R13");
    cyc(0, 0, 1, 1, 8'h01, 0, "R13");
    cyc(1, 0, 0, 0, 8'h00, 0, "R13 restart");
    cyc(0, 0, 1, 1, 8'h00, 0, "R13");
    cyc(0, 0, 1, 0, 8'h04, 0, "R13 id 2");
    cyc(0, 0, 1, 0, 8'h06, 0, "R12 extra byte ignored");
    cyc(0, 1, 0, 0, 8'h00, 0, "R12");
    idle("R12");
    idle("R12");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule